// File: doc/BRIEF.md
# HD Output Gain and Sync Inserter

This block conditions a pixel stream bound for a VGA monitor or an HDTV set. Three 10-bit channels arrive each pixel clock, carrying either RGB or Y/Pb/Pr samples. They leave as three 10-bit DAC codes, one output sample for every input pixel, after a fixed two-clock pipeline. No spatial scaling is done. Channel 0 carries G or Y, channel 1 carries B or Pb, and channel 2 carries R or Pr.

A static gain select picks one of two modes. In full-swing mode the codes pass through unchanged. In reduced mode the video is compressed by about 0.69 into the upper part of the code range, which frees the codes below it for a sync pulse. The pulse is then placed on channel 0 for displays that lock to sync carried on the video signal. The pulse is either a plain two-level pulse or a three-level pulse that swings below and then above the blank level. Horizontal sync and blanking timing come from an upstream timing generator. Both are delayed internally so that they line up with the pixels.

Top module: `hd_sync_gain`

## Requirements
- R1: In full-swing mode (`cfg_reduce`=0), a non-blanked pixel is driven unchanged on its channel exactly two clock edges after it is sampled.
- R2: In reduced mode, a non-blanked pixel x outside sync is driven as floor((x*707 + 512)/1024) + 317. For example, 0 gives 317, 512 gives 671 and 1023 gives 1023.
- R3: In full-swing mode, blanking drives code 0 on every channel for RGB (`cfg_ypbpr`=0). For Y/Pb/Pr (`cfg_ypbpr`=1) it drives 0 on channel 0 and 512 on channels 1 and 2.
- R4: In reduced mode, blanking outside sync drives the blank level 317 on all three channels.
- R5: In reduced mode with two-level sync (`cfg_trilevel`=0), channel 0 is code 0 for every cycle that sync is active.
- R6: In reduced mode with three-level sync (`cfg_trilevel`=1), channel 0 is code 0 for the first HALF_W cycles of a sync pulse and code 634 for the rest of it. It goes back to the blank or video level once sync ends.
- R7: Sync is inserted on channel 0 only. During sync in reduced mode, channels 1 and 2 carry 317.
- R8: In full-swing mode the sync input has no effect on any output.
- R9: In reduced mode, sync takes precedence over blanking and over the pixel value.
- R10: While reset is asserted, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reduce | input | 1 | 1 = reduced amplitude with sync insertion, 0 = full swing |
| cfg_trilevel | input | 1 | 1 = three-level sync, 0 = two-level sync |
| cfg_ypbpr | input | 1 | 1 = Y/Pb/Pr input, 0 = RGB input |
| pix_ch0 | input | 10 | G or Y sample |
| pix_ch1 | input | 10 | B or Pb sample |
| pix_ch2 | input | 10 | R or Pr sample |
| sync_in | input | 1 | Horizontal sync active |
| blank_in | input | 1 | Blanking active |
| dac_ch0 | output | 10 | DAC code, channel 0 |
| dac_ch1 | output | 10 | DAC code, channel 1 |
| dac_ch2 | output | 10 | DAC code, channel 2 |

## Verification
The hardest case to reach is the change from the low to the high half of a three-level pulse. It depends on how long sync has already been held, and that count is not visible at any port. The bench builds the design with a short half-width. It then holds sync for a counted number of pixel cycles, sometimes with blanking and sometimes without, and tracks the run length in its own model. This lets it predict the exact cycle where channel 0 moves from 0 to 634 and the cycle where it returns to blank. Pulses of one cycle and of exactly the half-width are also driven, so that the boundary of the counter is hit.

// File: rtl/hdg_pkg.sv
package hdg_pkg;
    // Fixed-point gain used in reduced mode: NUM / 2**SH ~= 0.69
    localparam int GAIN_NUM   = 707;
    localparam int GAIN_SHIFT = 10;
    localparam int NCH        = 3;
endpackage

// File: rtl/hdg_scale.sv
module hdg_scale #(
    parameter int DW    = 10,
    parameter int NUM   = 707,
    parameter int SH    = 10,
    parameter int OFS   = 317
) (
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam int PW = DW + SH + 1;
    localparam logic [PW-1:0] NUM_C  = PW'(NUM);
    localparam logic [PW-1:0] HALF_C = PW'(1 << (SH - 1));
    localparam logic [DW-1:0] OFS_C  = DW'(OFS);

    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(x) * NUM_C + HALF_C;
        shifted = prod >> SH;
        y       = DW'(shifted) + OFS_C;
    end
endmodule

// File: rtl/hdg_tri_phase.sv
module hdg_tri_phase #(
    parameter int HALF_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic high_q
);
    localparam int CW = $clog2(HALF_W + 1) + 1;
    localparam logic [CW-1:0] HALF_C = CW'(HALF_W);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          high;
    } tri_st_t;

    tri_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_in) begin
            st_d.run  = (st_q.run >= HALF_C) ? st_q.run : st_q.run + CW'(1);
            st_d.high = (st_q.run >= HALF_C);
        end else begin
            st_d.run  = '0;
            st_d.high = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign high_q = st_q.high;

    // R6: run length never exceeds its saturation point
    p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= HALF_C);
endmodule

// File: rtl/hd_sync_gain.sv
module hd_sync_gain #(
    parameter int DW     = 10,
    parameter int HALF_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_reduce,
    input  logic          cfg_trilevel,
    input  logic          cfg_ypbpr,
    input  logic [DW-1:0] pix_ch0,
    input  logic [DW-1:0] pix_ch1,
    input  logic [DW-1:0] pix_ch2,
    input  logic          sync_in,
    input  logic          blank_in,
    output logic [DW-1:0] dac_ch0,
    output logic [DW-1:0] dac_ch1,
    output logic [DW-1:0] dac_ch2
);
    import hdg_pkg::*;

    localparam int FULL   = (1 << DW) - 1;
    localparam int SPAN   = (FULL * GAIN_NUM + (1 << (GAIN_SHIFT - 1))) >> GAIN_SHIFT;
    localparam int OFS    = FULL - SPAN;
    localparam int TRI_HI = 2 * OFS;
    localparam int MID    = 1 << (DW - 1);
    localparam logic [DW-1:0] OFS_C = DW'(OFS);
    localparam logic [DW-1:0] TRI_C = DW'(TRI_HI);
    localparam logic [DW-1:0] MID_C = DW'(MID);

    typedef struct packed {
        logic                   reduce;
        logic                   tri_lvl;
        logic                   ypbpr;
        logic                   sync;
        logic                   blank;
        logic [NCH-1:0][DW-1:0] raw;
        logic [NCH-1:0][DW-1:0] scaled;
    } s1_t;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] dac;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic [NCH-1:0][DW-1:0] pix_in;
    logic [NCH-1:0][DW-1:0] pix_scaled;
    logic                   tri_high_q;

    assign pix_in = {pix_ch2, pix_ch1, pix_ch0};

    for (genvar gi = 0; gi < NCH; gi++) begin : g_scale
        hdg_scale #(
            .DW (DW),
            .NUM(GAIN_NUM),
            .SH (GAIN_SHIFT),
            .OFS(OFS)
        ) i_scale (
            .x(pix_in[gi]),
            .y(pix_scaled[gi])
        );
    end

    hdg_tri_phase #(.HALF_W(HALF_W)) i_tri (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_in(sync_in),
        .high_q (tri_high_q)
    );

    // Stage 1: capture pixels, scaled pixels, timing and configuration
    always_comb begin
        s1_d.reduce  = cfg_reduce;
        s1_d.tri_lvl = cfg_trilevel;
        s1_d.ypbpr   = cfg_ypbpr;
        s1_d.sync    = sync_in;
        s1_d.blank   = blank_in;
        s1_d.raw     = pix_in;
        s1_d.scaled  = pix_scaled;
    end

    // Stage 2: select the output code per channel
    always_comb begin
        s2_d = s2_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (!s1_q.reduce) begin
                if (s1_q.blank)
                    s2_d.dac[ch] = (ch != 0 && s1_q.ypbpr) ? MID_C : '0;
                else
                    s2_d.dac[ch] = s1_q.raw[ch];
            end else if (s1_q.sync) begin
                if (ch == 0)
                    s2_d.dac[ch] = (s1_q.tri_lvl && tri_high_q) ? TRI_C : '0;
                else
                    s2_d.dac[ch] = OFS_C;
            end else if (s1_q.blank) begin
                s2_d.dac[ch] = OFS_C;
            end else begin
                s2_d.dac[ch] = s1_q.scaled[ch];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dac_ch0 = s2_q.dac[0];
    assign dac_ch1 = s2_q.dac[1];
    assign dac_ch2 = s2_q.dac[2];

    // Assertion support: cycles since reset, configuration vector
    logic [1:0] age_q;
    logic [2:0] cfg_v;
    assign cfg_v = {cfg_reduce, cfg_trilevel, cfg_ypbpr};

    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cfg_v == $past(cfg_v) && cfg_v == $past(cfg_v, 2)
         && !$past(cfg_reduce, 2) && !$past(blank_in, 2))
        |-> (dac_ch1 == $past(pix_ch1, 2)));

    p_video_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cfg_v == $past(cfg_v) && cfg_v == $past(cfg_v, 2)
         && $past(cfg_reduce, 2) && !$past(sync_in, 2) && !$past(blank_in, 2))
        |-> (dac_ch0 >= OFS_C && dac_ch2 >= OFS_C));

    p_bilevel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cfg_v == $past(cfg_v) && cfg_v == $past(cfg_v, 2)
         && $past(cfg_reduce, 2) && !$past(cfg_trilevel, 2) && $past(sync_in, 2))
        |-> (dac_ch0 == '0));

    p_tri_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cfg_v == $past(cfg_v) && cfg_v == $past(cfg_v, 2)
         && cfg_v == $past(cfg_v, 3) && cfg_reduce && cfg_trilevel && dac_ch0 == TRI_C)
        |-> ($past(dac_ch0) == '0 || $past(dac_ch0) == TRI_C));

    p_side_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cfg_v == $past(cfg_v) && cfg_v == $past(cfg_v, 2)
         && $past(cfg_reduce, 2) && $past(sync_in, 2))
        |-> (dac_ch1 == OFS_C && dac_ch2 == OFS_C));
endmodule

// File: tb/test_hd_sync_gain.sv
module test_hd_sync_gain;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_reduce = 1'b0, cfg_trilevel = 1'b0, cfg_ypbpr = 1'b0;
    logic [9:0] pix_ch0 = '0, pix_ch1 = '0, pix_ch2 = '0;
    logic       sync_in = 1'b0, blank_in = 1'b0;
    logic [9:0] dac_ch0, dac_ch1, dac_ch2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side configuration, applied at each step's drive point
    logic b_red = 1'b0, b_tri = 1'b0, b_ycc = 1'b0;
    int   brun = 0;

    logic [29:0] hexp [2];
    bit          hval [2];
    string       htag [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    hd_sync_gain #(.DW(10), .HALF_W(HALF)) i_hd_sync_gain (
        .clk(clk), .rst_n(rst_n),
        .cfg_reduce(cfg_reduce), .cfg_trilevel(cfg_trilevel), .cfg_ypbpr(cfg_ypbpr),
        .pix_ch0(pix_ch0), .pix_ch1(pix_ch1), .pix_ch2(pix_ch2),
        .sync_in(sync_in), .blank_in(blank_in),
        .dac_ch0(dac_ch0), .dac_ch1(dac_ch1), .dac_ch2(dac_ch2)
    );

    function automatic logic [9:0] scale(input logic [9:0] x);
        int v;
        v = ((int'(x) * 707 + 512) >> 10) + 317;
        return 10'(v);
    endfunction

    function automatic logic [9:0] model(input int ch, input logic [9:0] x,
                                         input logic s, input logic bl, input int run);
        if (!b_red) begin
            if (bl) return (ch != 0 && b_ycc) ? 10'd512 : 10'd0;
            return x;
        end
        if (s) begin
            if (ch != 0) return 10'd317;
            if (b_tri && run >= HALF) return 10'd634;
            return 10'd0;
        end
        if (bl) return 10'd317;
        return scale(x);
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp, input int ch);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d: actual %0d expected %0d", tag, ch, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c,
                        input logic s, input logic bl, input string tag);
        @(negedge clk);
        if (hval[1]) begin
            check(htag[1], dac_ch0, hexp[1][9:0], 0);
            check(htag[1], dac_ch1, hexp[1][19:10], 1);
            check(htag[1], dac_ch2, hexp[1][29:20], 2);
        end
        hexp[1] = hexp[0]; hval[1] = hval[0]; htag[1] = htag[0];
        cfg_reduce = b_red; cfg_trilevel = b_tri; cfg_ypbpr = b_ycc;
        pix_ch0 = a; pix_ch1 = b; pix_ch2 = c; sync_in = s; blank_in = bl;
        hexp[0] = {model(2, c, s, bl, brun), model(1, b, s, bl, brun), model(0, a, s, bl, brun)};
        hval[0] = 1'b1; htag[0] = tag;
        brun = s ? brun + 1 : 0;
    endtask

    task automatic flush(input string tag);
        step(10'd100, 10'd200, 10'd300, 1'b0, 1'b0, tag);
        step(10'd100, 10'd200, 10'd300, 1'b0, 1'b0, tag);
        step(10'd100, 10'd200, 10'd300, 1'b0, 1'b0, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        pix_ch0 = 10'd777; pix_ch1 = 10'd555; pix_ch2 = 10'd333;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", dac_ch0, 10'd0, 0);
        check("R10 reset", dac_ch1, 10'd0, 1);
        check("R10 reset", dac_ch2, 10'd0, 2);
        hval[0] = 1'b0; hval[1] = 1'b0; brun = 0;
        rst_n = 1'b1;
    endtask

    task automatic t_full_pass;
        b_red = 1'b0; b_ycc = 1'b0;
        step(10'd0,    10'd1023, 10'd512, 1'b0, 1'b0, "R1 pass");
        step(10'd1023, 10'd0,    10'd1,   1'b0, 1'b0, "R1 pass");
        step(10'd341,  10'd682,  10'd999, 1'b0, 1'b0, "R1 pass");
        flush("R1 pass");
    endtask

    task automatic t_full_blank;
        b_red = 1'b0; b_ycc = 1'b0;
        step(10'd900, 10'd900, 10'd900, 1'b0, 1'b1, "R3 blank rgb");
        step(10'd900, 10'd900, 10'd900, 1'b0, 1'b1, "R3 blank rgb");
        b_ycc = 1'b1;
        step(10'd900, 10'd900, 10'd900, 1'b0, 1'b1, "R3 blank ypbpr");
        step(10'd10,  10'd10,  10'd10,  1'b0, 1'b1, "R3 blank ypbpr");
        flush("R3 blank");
    endtask

    task automatic t_full_sync_ignored;
        b_red = 1'b0; b_ycc = 1'b1; b_tri = 1'b1;
        for (int i = 0; i < 8; i++)
            step(10'(i * 100), 10'(i * 50 + 3), 10'd1023, 1'b1, 1'b0, "R8 sync ignored");
        step(10'd7, 10'd8, 10'd9, 1'b1, 1'b1, "R8 sync ignored blank");
        flush("R8 sync ignored");
    endtask

    task automatic t_reduced_scale;
        b_red = 1'b1; b_tri = 1'b0; b_ycc = 1'b0;
        step(10'd0,    10'd512, 10'd1023, 1'b0, 1'b0, "R2 scale");
        step(10'd1023, 10'd0,   10'd512,  1'b0, 1'b0, "R2 scale");
        step(10'd1,    10'd2,   10'd700,  1'b0, 1'b0, "R2 scale");
        flush("R2 scale");
        // literal end points from the requirement
        step(10'd0, 10'd512, 10'd1023, 1'b0, 1'b0, "R2 literal");
        step(10'd0, 10'd0, 10'd0, 1'b0, 1'b0, "R2 literal");
        @(negedge clk);
        check("R2 literal", dac_ch0, 10'd317, 0);
        check("R2 literal", dac_ch1, 10'd671, 1);
        check("R2 literal", dac_ch2, 10'd1023, 2);
        hval[0] = 1'b0; hval[1] = 1'b0;
        flush("R2 scale");
    endtask

    task automatic t_reduced_blank;
        b_red = 1'b1; b_ycc = 1'b1;
        step(10'd1000, 10'd1000, 10'd1000, 1'b0, 1'b1, "R4 reduced blank");
        step(10'd0,    10'd0,    10'd0,    1'b0, 1'b1, "R4 reduced blank");
        flush("R4 reduced blank");
    endtask

    task automatic t_bilevel;
        b_red = 1'b1; b_tri = 1'b0; b_ycc = 1'b0;
        for (int i = 0; i < 6; i++)
            step(10'd800, 10'd800, 10'd800, 1'b1, 1'b0, "R5 R7 bilevel");
        for (int i = 0; i < 3; i++)
            step(10'd900, 10'd400, 10'd600, 1'b1, 1'b1, "R9 sync over blank");
        step(10'd900, 10'd400, 10'd600, 1'b0, 1'b1, "R4 after sync");
        flush("R5 bilevel");
    endtask

    task automatic t_trilevel;
        b_red = 1'b1; b_tri = 1'b1; b_ycc = 1'b1;
        // long pulse: HALF low cycles then high half
        for (int i = 0; i < 10; i++)
            step(10'd500, 10'd500, 10'd500, 1'b1, 1'b1, "R6 tri long");
        step(10'd500, 10'd500, 10'd500, 1'b0, 1'b1, "R6 tri return blank");
        step(10'd500, 10'd500, 10'd500, 1'b0, 1'b0, "R6 tri return video");
        // pulse exactly HALF long never reaches the high half
        for (int i = 0; i < HALF; i++)
            step(10'd20, 10'd20, 10'd20, 1'b1, 1'b0, "R6 tri boundary");
        step(10'd20, 10'd20, 10'd20, 1'b0, 1'b0, "R6 tri boundary");
        // pulse HALF+1 long: one high cycle
        for (int i = 0; i < HALF + 1; i++)
            step(10'd40, 10'd40, 10'd40, 1'b1, 1'b0, "R6 tri boundary+1");
        // one-cycle pulse
        step(10'd60, 10'd60, 10'd60, 1'b0, 1'b0, "R6 tri single");
        step(10'd60, 10'd60, 10'd60, 1'b1, 1'b0, "R6 tri single");
        flush("R6 tri");
    endtask

    initial begin
        t_reset();
        t_full_pass();
        t_full_blank();
        t_full_sync_ignored();
        t_reduced_scale();
        t_reduced_blank();
        t_bilevel();
        t_trilevel();
        t_reset();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule